// File: doc/BRIEF.md
# Interrupt Source Dispatcher

This block keeps the per-source configuration of a multi-processor interrupt controller and turns source-line activity into delivery strobes for the per-processor units. Each source owns two 32-bit words: a control word that holds a mask flag, a 4-bit priority, an 8-bit vector and a hardware-owned in-service flag, and a target word that holds one enable bit per processor. Software reaches both words through a simple write port and a combinational read port.

A rising edge on a source line, or a control-word write while the line is high, queues that source for evaluation. One queued source is evaluated per clock, lowest index first. A source that is masked, has priority zero, is already in service or targets no processor is dropped. Otherwise a one-cycle strobe goes to exactly one processor together with the source index, vector and priority, and the in-service flag is set. A source that targets several processors rotates its deliveries among them. The per-processor acknowledge path clears the in-service flag through a dedicated clear input.

Top module: `irq_src_dispatch`

## Requirements
- R1: After reset every control word reads 0xA0000000 (mask set, in-service clear), every target word reads 0 and no strobe is driven.
- R2: Source n's control word is at byte offset 32*n and its target word at 32*n+16. Accesses whose offset bits 3:0 are not zero write nothing and read 0. A control-word write stores only data bits 31, 19:16 and 7:0 (mask 0x800F00FF). Bit 30, the in-service flag, keeps its value, and every other bit reads 0 afterwards.
- R3: A target-word write keeps data bits 31:30 and the low NCPU bits (0xC0000003 for two processors), and the rest reads 0. Only the low NCPU bits select processors.
- R4: A source line rising before clock edge A, with a deliverable configuration, produces a strobe after edge A+1. The strobe sets exactly one bit of raise_cpu for one cycle, with raise_idx, raise_vec and raise_prio taken from that source, and it sets control-word bit 30.
- R5: A source whose mask bit (31) is set is dropped.
- R6: A source whose priority field (bits 19:16) is zero is dropped.
- R7: A source whose in-service flag (bit 30) is set is dropped, and further line edges do not deliver it until the flag is cleared.
- R8: A source whose target processor bits are all zero is dropped.
- R9: A control-word write to a source whose line is high queues that source again, so an unmasking write delivers one cycle after the write edge.
- R10: Each source remembers the last processor it was delivered to (processor 0 after reset). The next delivery goes to the next enabled processor above it, wrapping around, so a single enabled processor is always chosen directly.
- R11: Sources queued in the same cycle are delivered one per clock, lowest index first.
- R12: ack_clr with ack_idx clears that source's in-service flag at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Source request lines, a rising edge queues evaluation |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| ack_clr | input | 1 | Clear the in-service flag of ack_idx |
| ack_idx | input | IW | Source whose in-service flag is cleared |
| raise_cpu | output | NCPU | One-hot delivery strobe per processor |
| raise_idx | output | IW | Index of the delivered source |
| raise_vec | output | 8 | Vector of the delivered source |
| raise_prio | output | 4 | Priority of the delivered source |

## Verification
A wrong in-service flag shows up in two ways: a missing or duplicated strobe on the next line edge of that source, and bit 30 of the control word on the read port in the same cycle. A stale last-processor record shows up as a wrong raise_cpu bit on the next multi-target delivery. A lost or duplicated queue entry shows up within two clocks as a missing, doubled or misordered raise_idx. Read-back after each kind of write exposes write-mask errors without delay.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;
   localparam int          WORD_W     = 32;
   localparam int          MASK_BIT   = 31;
   localparam int          SERV_BIT   = 30;
   localparam int          PRIO_LSB   = 16;
   localparam int          PRIO_W     = 4;
   localparam int          VEC_W      = 8;
   localparam int          SLOT_SHIFT = 5;
   localparam logic [31:0] CTRL_RST   = 32'hA000_0000;
   localparam logic [31:0] CTRL_WMASK = 32'h800F_00FF;
   localparam logic [31:0] TGT_HMASK  = 32'hC000_0000;
endpackage

// File: rtl/sdisp_arb.sv
module sdisp_arb #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic [N-1:0]  req,
   output logic          grant_v,
   output logic [IW-1:0] grant_idx
);
   always_comb begin
      grant_v   = 1'b0;
      grant_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant_v   = 1'b1;
            grant_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/sdisp_rotor.sv
module sdisp_rotor #(
   parameter int NCPU = 2,
   parameter int CW   = 1
) (
   input  logic [NCPU-1:0] tgt,
   input  logic [CW-1:0]   last,
   output logic [NCPU-1:0] pick_oh,
   output logic [CW-1:0]   pick_idx
);
   if (NCPU == 1) begin : g_single
      logic unused_last;
      assign unused_last = ^last;
      assign pick_oh     = tgt;
      assign pick_idx    = '0;
   end else begin : g_multi
      always_comb begin
         logic found;
         int   c;
         found    = 1'b0;
         pick_oh  = '0;
         pick_idx = last;
         for (int k = 1; k <= NCPU; k++) begin
            c = (int'(last) + k) % NCPU;
            if (!found && tgt[c]) begin
               found       = 1'b1;
               pick_oh     = '0;
               pick_oh[c]  = 1'b1;
               pick_idx    = CW'(c);
            end
         end
      end
   end
endmodule

// File: rtl/sdisp_regs.sv
module sdisp_regs
   import sdisp_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int NCPU = 2,
   parameter int IW   = 5,
   parameter int AW   = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [31:0]                wr_data,
   input  logic [AW-1:0]              rd_addr,
   output logic [31:0]                rd_data,
   input  logic                       set_v,
   input  logic [IW-1:0]              set_idx,
   input  logic                       clr_v,
   input  logic [IW-1:0]              clr_idx,
   output logic [NSRC-1:0]            mask_o,
   output logic [NSRC-1:0]            serv_o,
   output logic [NSRC-1:0][PRIO_W-1:0] prio_o,
   output logic [NSRC-1:0][VEC_W-1:0]  vec_o,
   output logic [NSRC-1:0][NCPU-1:0]  tgt_o,
   output logic [NSRC-1:0]            ctrl_wr_o
);
   localparam logic [31:0] TGT_WMASK = TGT_HMASK | 32'((64'd1 << NCPU) - 64'd1);

   logic [NSRC-1:0][31:0] ctrl_q;
   logic [NSRC-1:0][31:0] tgt_q;

   wire          wr_ok  = wr_en && (wr_addr[3:0] == 4'd0);
   wire [IW-1:0] wr_idx = wr_addr[AW-1:SLOT_SHIFT];
   wire          wr_tgt = wr_addr[4];
   wire [IW-1:0] rd_idx = rd_addr[AW-1:SLOT_SHIFT];

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      wire hit     = wr_ok && (wr_idx == IW'(i));
      wire ctrl_we = hit && !wr_tgt;
      wire tgt_we  = hit && wr_tgt;
      wire serv_set = set_v && (set_idx == IW'(i));
      wire serv_clr = clr_v && (clr_idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[i] <= CTRL_RST;
            tgt_q[i]  <= '0;
         end else begin
            if (ctrl_we)
               ctrl_q[i] <= (ctrl_q[i] & (32'd1 << SERV_BIT)) | (wr_data & CTRL_WMASK);
            if (serv_set)
               ctrl_q[i][SERV_BIT] <= 1'b1;
            else if (serv_clr)
               ctrl_q[i][SERV_BIT] <= 1'b0;
            if (tgt_we)
               tgt_q[i] <= wr_data & TGT_WMASK;
         end
      end

      assign mask_o[i]    = ctrl_q[i][MASK_BIT];
      assign serv_o[i]    = ctrl_q[i][SERV_BIT];
      assign prio_o[i]    = ctrl_q[i][PRIO_LSB +: PRIO_W];
      assign vec_o[i]     = ctrl_q[i][VEC_W-1:0];
      assign tgt_o[i]     = tgt_q[i][NCPU-1:0];
      assign ctrl_wr_o[i] = ctrl_we;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr[3:0] == 4'd0 && int'(rd_idx) < NSRC)
         rd_data = rd_addr[4] ? tgt_q[rd_idx] : ctrl_q[rd_idx];
   end
endmodule

// File: rtl/irq_src_dispatch.sv
module irq_src_dispatch
   import sdisp_pkg::*;
#(
   parameter int  NSRC = 32,
   parameter int  NCPU = 2,
   localparam int IW   = $clog2(NSRC),
   localparam int AW   = IW + SLOT_SHIFT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [31:0]     wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [31:0]     rd_data,
   input  logic            ack_clr,
   input  logic [IW-1:0]   ack_idx,
   output logic [NCPU-1:0] raise_cpu,
   output logic [IW-1:0]   raise_idx,
   output logic [7:0]      raise_vec,
   output logic [3:0]      raise_prio
);
   localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1;

   if (NSRC < 2) begin : g_bad_nsrc
      $error("irq_src_dispatch: NSRC must be at least 2");
   end
   if (NCPU < 1 || NCPU > 30) begin : g_bad_ncpu
      $error("irq_src_dispatch: NCPU must be within 1..30");
   end

   logic [NSRC-1:0]              mask_vec, act_vec, ctrl_wr;
   logic [NSRC-1:0][PRIO_W-1:0]  prio_vec;
   logic [NSRC-1:0][VEC_W-1:0]   vec_vec;
   logic [NSRC-1:0][NCPU-1:0]    tgt_vec;
   logic [NSRC-1:0]              src_q, eval_q;
   logic [NSRC-1:0][CW-1:0]      last_q;

   logic                         pick_v;
   logic [IW-1:0]                pick_idx;
   logic [NCPU-1:0]              rot_oh;
   logic [CW-1:0]                rot_idx;
   logic                         deliver;

   sdisp_regs #(.NSRC(NSRC), .NCPU(NCPU), .IW(IW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .set_v(deliver), .set_idx(pick_idx),
      .clr_v(ack_clr), .clr_idx(ack_idx),
      .mask_o(mask_vec), .serv_o(act_vec), .prio_o(prio_vec),
      .vec_o(vec_vec), .tgt_o(tgt_vec), .ctrl_wr_o(ctrl_wr)
   );

   sdisp_arb #(.N(NSRC), .IW(IW)) u_arb (
      .req(eval_q), .grant_v(pick_v), .grant_idx(pick_idx)
   );

   sdisp_rotor #(.NCPU(NCPU), .CW(CW)) u_rot (
      .tgt(tgt_vec[pick_idx]), .last(last_q[pick_idx]),
      .pick_oh(rot_oh), .pick_idx(rot_idx)
   );

   assign deliver = pick_v
                    && !mask_vec[pick_idx]
                    && (prio_vec[pick_idx] != '0)
                    && !act_vec[pick_idx]
                    && (tgt_vec[pick_idx] != '0);

   wire [NSRC-1:0] done_oh = pick_v ? (NSRC'(1) << pick_idx) : '0;
   wire [NSRC-1:0] new_req = (src_in & ~src_q) | (ctrl_wr & src_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q      <= '0;
         eval_q     <= '0;
         last_q     <= '0;
         raise_cpu  <= '0;
         raise_idx  <= '0;
         raise_vec  <= '0;
         raise_prio <= '0;
      end else begin
         src_q     <= src_in;
         eval_q    <= (eval_q & ~done_oh) | new_req;
         raise_cpu <= deliver ? rot_oh : '0;
         if (deliver) begin
            raise_idx          <= pick_idx;
            raise_vec          <= vec_vec[pick_idx];
            raise_prio         <= prio_vec[pick_idx];
            last_q[pick_idx]   <= rot_idx;
         end
      end
   end
endmodule

// File: rtl/irq_src_dispatch_chk.sv
module irq_src_dispatch_chk #(
   parameter int NSRC = 32,
   parameter int NCPU = 2,
   parameter int IW   = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NCPU-1:0] raise_cpu,
   input logic [IW-1:0]   raise_idx,
   input logic [3:0]      raise_prio,
   input logic [NSRC-1:0] act_vec,
   input logic            ack_clr,
   input logic [IW-1:0]   ack_idx
);
   p_onehot_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(raise_cpu));

   p_serv_on_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|raise_cpu) |-> act_vec[raise_idx]);

   p_prio_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|raise_cpu) |-> (raise_prio != 4'd0));

   p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|raise_cpu) |=> !((|raise_cpu) && (raise_idx == $past(raise_idx))));

   p_serv_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ack_clr |=> (!act_vec[$past(ack_idx)]
                   || ((|raise_cpu) && (raise_idx == $past(ack_idx)))));
endmodule

bind irq_src_dispatch irq_src_dispatch_chk #(.NSRC(NSRC), .NCPU(NCPU), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .raise_cpu(raise_cpu), .raise_idx(raise_idx),
   .raise_prio(raise_prio), .act_vec(act_vec), .ack_clr(ack_clr), .ack_idx(ack_idx)
);

// File: tb/irq_src_dispatch_tb_top.sv
module irq_src_dispatch_tb_top;
   localparam int CLK_P = 10;
   localparam int NSRC  = 32;
   localparam int NCPU  = 2;
   localparam int IW    = 5;
   localparam int AW    = 10;
   localparam int NVEC  = 7;

   localparam logic [31:0] TV_CTRL [NVEC] = '{32'h0005_0011, 32'h0003_0022, 32'h8005_0033,
                                              32'h0000_0044, 32'h0007_0055, 32'h000F_0066,
                                              32'h4001_0077};
   localparam logic [31:0] TV_TGT  [NVEC] = '{32'h1, 32'h2, 32'h1, 32'h1, 32'h0,
                                              32'hC000_0002, 32'h1};
   localparam logic [1:0]  TV_EXP  [NVEC] = '{2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b01};
   localparam string       TV_TAG  [NVEC] = '{"R4", "R4", "R5", "R6", "R8", "R3", "R2"};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_in = '0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [31:0]     rd_data;
   logic            ack_clr = 1'b0;
   logic [IW-1:0]   ack_idx = '0;
   logic [NCPU-1:0] raise_cpu;
   logic [IW-1:0]   raise_idx;
   logic [7:0]      raise_vec;
   logic [3:0]      raise_prio;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_src_dispatch #(.NSRC(NSRC), .NCPU(NCPU)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack_clr(ack_clr),
      .ack_idx(ack_idx), .raise_cpu(raise_cpu), .raise_idx(raise_idx),
      .raise_vec(raise_vec), .raise_prio(raise_prio)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ctrl_a(input int n);
      return AW'(n * 32);
   endfunction
   function automatic logic [AW-1:0] tgt_a(input int n);
      return AW'(n * 32 + 16);
   endfunction

   task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic clear_serv(input int n);
      ack_clr = 1'b1; ack_idx = IW'(n);
      @(negedge clk);
      ack_clr = 1'b0;
   endtask

   task automatic fire(input int n, input logic [1:0] exp_cpu, input logic [31:0] ctrl,
                       input string tag);
      src_in[n] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(32'(raise_cpu), 32'(exp_cpu), {tag, " strobe"});
      if (exp_cpu != 2'b00) begin
         check(32'(raise_idx), 32'(n), {tag, " index"});
         check(32'(raise_vec), 32'(ctrl[7:0]), {tag, " vector"});
         check(32'(raise_prio), 32'(ctrl[19:16]), {tag, " priority"});
      end
      @(negedge clk);
      check(32'(raise_cpu), 32'h0, {tag, " strobe one cycle"});
      src_in[n] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_rd(ctrl_a(20), d); check(d, 32'hA000_0000, "R1 control reset");
      reg_rd(tgt_a(20), d);  check(d, 32'h0, "R1 target reset");
      check(32'(raise_cpu), 32'h0, "R1 no strobe");

      // vector table walk: R2 R3 R4 R5 R6 R8
      for (int i = 0; i < NVEC; i++) begin
         reg_wr(ctrl_a(i), TV_CTRL[i]);
         reg_wr(tgt_a(i), TV_TGT[i]);
         fire(i, TV_EXP[i], TV_CTRL[i], TV_TAG[i]);
      end

      // R2 bit 30 not writable, masked write
      reg_rd(ctrl_a(4), d); check(d, 32'h0007_0055, "R2 control readback");
      reg_wr(ctrl_a(12), 32'hFFFF_FFFF);
      reg_rd(ctrl_a(12), d); check(d, 32'h800F_00FF, "R2 write mask");
      reg_wr(ctrl_a(12) | AW'(4), 32'h0001_0001);
      reg_rd(ctrl_a(12), d); check(d, 32'h800F_00FF, "R2 misaligned write ignored");
      reg_rd(ctrl_a(12) | AW'(8), d); check(d, 32'h0, "R2 misaligned read zero");
      // R3 target write mask
      reg_wr(tgt_a(12), 32'hFFFF_FFFF);
      reg_rd(tgt_a(12), d); check(d, 32'hC000_0003, "R3 target mask");

      // R7 in-service source dropped, R12 clear
      reg_rd(ctrl_a(0), d); check(d, 32'h4005_0011, "R4 in-service flag set");
      fire(0, 2'b00, TV_CTRL[0], "R7");
      clear_serv(0);
      reg_rd(ctrl_a(0), d); check(d, 32'h0005_0011, "R12 flag cleared");
      fire(0, 2'b01, TV_CTRL[0], "R12");

      // R10 rotation across both processors
      reg_wr(ctrl_a(8), 32'h0001_0088);
      reg_wr(tgt_a(8), 32'h3);
      fire(8, 2'b10, 32'h0001_0088, "R10 first");
      clear_serv(8);
      fire(8, 2'b01, 32'h0001_0088, "R10 second");
      clear_serv(8);
      fire(8, 2'b10, 32'h0001_0088, "R10 third");

      // R11 simultaneous sources, lowest index first
      reg_wr(ctrl_a(9), 32'h0002_0009);  reg_wr(tgt_a(9), 32'h1);
      reg_wr(ctrl_a(10), 32'h0002_000A); reg_wr(tgt_a(10), 32'h1);
      src_in[9] = 1'b1; src_in[10] = 1'b1;
      @(negedge clk); @(negedge clk);
      check(32'(raise_cpu), 32'h1, "R11 first strobe");
      check(32'(raise_idx), 32'd9, "R11 first index");
      @(negedge clk);
      check(32'(raise_cpu), 32'h1, "R11 second strobe");
      check(32'(raise_idx), 32'd10, "R11 second index");
      @(negedge clk);
      check(32'(raise_cpu), 32'h0, "R11 queue empty");
      src_in[9] = 1'b0; src_in[10] = 1'b0;
      @(negedge clk);

      // R9 unmasking write while line is high
      reg_wr(ctrl_a(11), 32'h8002_0099);
      reg_wr(tgt_a(11), 32'h1);
      src_in[11] = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      check(32'(raise_cpu), 32'h0, "R9 masked line held");
      reg_wr(ctrl_a(11), 32'h0002_0099);
      @(negedge clk);
      check(32'(raise_cpu), 32'h1, "R9 strobe after write");
      check(32'(raise_idx), 32'd11, "R9 index");
      check(32'(raise_vec), 32'h99, "R9 vector");
      src_in[11] = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule